// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings a dynamic memory out of power-up and then keeps its contents alive. After reset it holds every memory strobe inactive for a configurable pause. It then runs a back-to-back train of initialization cycles, each one a refresh in which the column strobe drops before the row strobe. Once this is done it raises `init_done`. From then on, a free-running interval timer books one refresh per interval into a small backlog counter.

While the backlog is non-zero the block asks the access controller for the memory through `ref_req`. When `ref_grant` is seen in idle, it takes the strobes (`strobe_own` high) and performs a column-before-row refresh, then hands them back. Every such cycle uses the memory's own internal row counter, so no address is driven. If the backlog still holds work and the grant is still held, the column strobe stays low and only the row strobe is pulsed again. A full backlog raises `ref_urgent` so that the controller can stop starting new host cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `mem_ras_n`, `mem_cas_n`, `mem_we_n` and `mem_oe_n` are all 1, and `init_done`, `ref_req`, `ref_urgent` and `strobe_own` are all 0.
- R2: The first strobe activity is `mem_cas_n` going to 0 exactly PAUSE_CYC clock edges after reset is released. Neither strobe goes low before that.
- R3: Initialization is one uninterrupted span of `mem_cas_n` = 0 that contains exactly INIT_CYC row-strobe pulses. `init_done` rises on the same edge at which `mem_cas_n` returns to 1, which is PAUSE_CYC + LEAD_CYC + INIT_CYC·(ACT_CYC+PRE_CYC) edges after reset release. `ref_req` and `ref_urgent` stay 0 until then.
- R4: On every falling edge of `mem_ras_n`, `mem_cas_n` is 0 both in that cycle and in the cycle before.
- R5: `mem_we_n` and `mem_oe_n` are 1 in every cycle. Write enable high keeps refresh cycles out of the memory's test mode, and output enable high keeps the data pins high-impedance.
- R6: `ref_req` first rises exactly REFRESH_INTERVAL edges after `init_done` rises. One refresh is then owed every REFRESH_INTERVAL cycles after that.
- R7: A refresh cycle starts only from idle with `ref_grant` = 1. `strobe_own` and a low `mem_cas_n` appear one edge after the grant is sampled. While `ref_grant` stays 0, no strobe moves and `strobe_own` stays 0, however large the backlog grows.
- R8: The backlog saturates at MAX_POSTPONE, and interval ticks beyond that are dropped. `ref_urgent` is 1 exactly when the backlog equals MAX_POSTPONE, and `ref_req` is 1 whenever `ref_urgent` is.
- R9: With CHAIN_BURST = 1, if work is still owed and `ref_grant` is still 1 at the end of a refresh's precharge, the next refresh reuses the low `mem_cas_n` and only the row strobe pulses again. A single owed refresh yields a span with one pulse.
- R10: An interval tick and the completion of a refresh may land on the same edge. Both are counted, so every non-dropped tick is serviced exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Access controller hands the strobes to this block |
| ref_req | output | 1 | Refresh owed or in progress |
| ref_urgent | output | 1 | Backlog full; controller should stop starting host cycles |
| init_done | output | 1 | Pause and initialization cycles complete |
| strobe_own | output | 1 | This block is driving the memory strobes |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_oe_n | output | 1 | Output enable, held high |

## Verification
The two events that can share one edge are the interval tick that adds a refresh to the backlog and the end of a row-strobe pulse that removes one. The bench provokes this by releasing the grant after a full backlog at a chosen offset, so that the third completion of the burst falls on the edge of the next tick. The result is judged by the length of the burst: the single column-strobe span must hold exactly nine row pulses (eight saved plus one new), and the request must drop once the span ends. The same scoreboard also checks bursts from a saturated backlog with no tick inside them, where exactly eight pulses are expected and dropped ticks leave no trace.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   typedef enum logic [2:0] {
      ST_PAUSE = 3'd0,
      ST_IDLE  = 3'd1,
      ST_LEAD  = 3'd2,
      ST_ACT   = 3'd3,
      ST_PRE   = 3'd4
   } rfs_state_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (INTERVAL == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(INTERVAL);
         localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (run) begin
               if (cnt == LAST) cnt <= '0;
               else             cnt <= cnt + 1'b1;
            end
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
   parameter int MAX_POSTPONE = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic done,
   output logic owed,
   output logic full
);
   localparam int CW = $clog2(MAX_POSTPONE + 1);
   localparam logic [CW:0] CAP = (CW+1)'(MAX_POSTPONE);

   logic [CW-1:0] count;
   logic [CW:0]   sum;

   always_comb begin
      sum = {1'b0, count} + (CW+1)'(tick) - (CW+1)'(done);
      if (sum > CAP) sum = CAP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= sum[CW-1:0];
   end

   assign owed = (count != '0);
   assign full = ({1'b0, count} == CAP);
endmodule

// File: rtl/rfs_cycle_fsm.sv
module rfs_cycle_fsm
   import rfs_pkg::*;
#(
   parameter int PAUSE_CYC   = 20000,
   parameter int INIT_CYC    = 8,
   parameter int LEAD_CYC    = 2,
   parameter int ACT_CYC     = 8,
   parameter int PRE_CYC     = 6,
   parameter bit CHAIN_BURST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   input  logic owed,
   output logic init_done,
   output logic done,
   output logic own,
   output logic ras_n,
   output logic cas_n
);
   localparam int MAXPH = max4(PAUSE_CYC, LEAD_CYC, ACT_CYC, PRE_CYC);
   localparam int PW    = $clog2(MAXPH + 1);
   localparam int IW    = $clog2(INIT_CYC + 1);

   rfs_state_t    state;
   logic [PW-1:0] phase;
   logic [IW-1:0] init_left;
   logic          phase_end;
   logic          chain_ok;
   logic          again;

   generate
      if (CHAIN_BURST) begin : g_chain
         assign chain_ok = owed && grant;
      end else begin : g_single
         assign chain_ok = 1'b0;
      end
   endgenerate

   assign phase_end = (phase == '0);
   assign again     = init_done ? chain_ok : (init_left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_PAUSE;
         phase     <= PW'(PAUSE_CYC - 1);
         init_left <= IW'(INIT_CYC);
         init_done <= 1'b0;
      end else begin
         case (state)
            ST_PAUSE: begin
               if (phase_end) begin
                  state <= ST_LEAD;
                  phase <= PW'(LEAD_CYC - 1);
               end else begin
                  phase <= phase - 1'b1;
               end
            end
            ST_IDLE: begin
               if (init_done && owed && grant) begin
                  state <= ST_LEAD;
                  phase <= PW'(LEAD_CYC - 1);
               end
            end
            ST_LEAD: begin
               if (phase_end) begin
                  state <= ST_ACT;
                  phase <= PW'(ACT_CYC - 1);
               end else begin
                  phase <= phase - 1'b1;
               end
            end
            ST_ACT: begin
               if (phase_end) begin
                  state <= ST_PRE;
                  phase <= PW'(PRE_CYC - 1);
                  if (!init_done) init_left <= init_left - 1'b1;
               end else begin
                  phase <= phase - 1'b1;
               end
            end
            ST_PRE: begin
               if (phase_end) begin
                  if (again) begin
                     state <= ST_ACT;
                     phase <= PW'(ACT_CYC - 1);
                  end else begin
                     state <= ST_IDLE;
                     if (!init_done) init_done <= 1'b1;
                  end
               end else begin
                  phase <= phase - 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   assign done  = init_done && (state == ST_ACT) && phase_end;
   assign own   = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_PRE);
   assign ras_n = (state != ST_ACT);
   assign cas_n = !own;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int PAUSE_CYC        = 20000,
   parameter int INIT_CYC         = 8,
   parameter int REFRESH_INTERVAL = 1560,
   parameter int MAX_POSTPONE     = 8,
   parameter int LEAD_CYC         = 2,
   parameter int ACT_CYC          = 8,
   parameter int PRE_CYC          = 6,
   parameter bit CHAIN_BURST      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_grant,
   output logic ref_req,
   output logic ref_urgent,
   output logic init_done,
   output logic strobe_own,
   output logic mem_ras_n,
   output logic mem_cas_n,
   output logic mem_we_n,
   output logic mem_oe_n
);
   generate
      if (PAUSE_CYC < 1)        begin : g_bad_pause  $error("PAUSE_CYC must be at least 1");        end
      if (INIT_CYC < 1)         begin : g_bad_init   $error("INIT_CYC must be at least 1");         end
      if (REFRESH_INTERVAL < 1) begin : g_bad_intv   $error("REFRESH_INTERVAL must be at least 1"); end
      if (MAX_POSTPONE < 1)     begin : g_bad_post   $error("MAX_POSTPONE must be at least 1");     end
      if (LEAD_CYC < 1 || ACT_CYC < 1 || PRE_CYC < LEAD_CYC)
                                begin : g_bad_phase  $error("phase lengths out of range");          end
   endgenerate

   logic tick;
   logic done;
   logic owed;
   logic full;

   rfs_interval_timer #(
      .INTERVAL (REFRESH_INTERVAL)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (init_done),
      .tick  (tick)
   );

   rfs_backlog #(
      .MAX_POSTPONE (MAX_POSTPONE)
   ) u_backlog (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .done  (done),
      .owed  (owed),
      .full  (full)
   );

   rfs_cycle_fsm #(
      .PAUSE_CYC   (PAUSE_CYC),
      .INIT_CYC    (INIT_CYC),
      .LEAD_CYC    (LEAD_CYC),
      .ACT_CYC     (ACT_CYC),
      .PRE_CYC     (PRE_CYC),
      .CHAIN_BURST (CHAIN_BURST)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (ref_grant),
      .owed      (owed),
      .init_done (init_done),
      .done      (done),
      .own       (strobe_own),
      .ras_n     (mem_ras_n),
      .cas_n     (mem_cas_n)
   );

   assign ref_req    = init_done && (owed || strobe_own);
   assign ref_urgent = full;
   assign mem_we_n   = 1'b1;
   assign mem_oe_n   = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_grant,
   input logic ref_req,
   input logic ref_urgent,
   input logic init_done,
   input logic strobe_own,
   input logic mem_ras_n,
   input logic mem_cas_n
);
   // R4
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ras_n) |-> (!mem_cas_n && $past(!mem_cas_n)));

   // R7
   grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(strobe_own) && init_done) |-> $past(ref_grant));

   // R7
   idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_own |-> mem_ras_n);

   // R8
   urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> ref_req);

   // R3
   init_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (mem_cas_n && !strobe_own));

   // R3
   init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R3
   no_early_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !ref_urgent);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (.*);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PAUSE = 50;
   localparam int INIT  = 8;
   localparam int INTV  = 100;
   localparam int MAXP  = 8;
   localparam int LEAD  = 2;
   localparam int ACT   = 4;
   localparam int PRE   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_grant = 1'b0;
   logic ref_req, ref_urgent, init_done, strobe_own;
   logic mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];
   int span_pulses = 0;
   int ras_falls = 0;
   int first_cas_cyc = -1;
   int init_cyc = -1;
   int first_req_cyc = -1;
   bit early_req = 1'b0;
   bit prev_ras = 1'b1;
   bit prev_cas = 1'b1;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_refresh_seq #(
      .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REFRESH_INTERVAL(INTV),
      .MAX_POSTPONE(MAXP), .LEAD_CYC(LEAD), .ACT_CYC(ACT), .PRE_CYC(PRE),
      .CHAIN_BURST(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant),
      .ref_req(ref_req), .ref_urgent(ref_urgent), .init_done(init_done),
      .strobe_own(strobe_own), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic expect_span(input int pulses);
      exp_q.push_back(pulses);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Monitor: scoreboard of column-strobe spans
   always @(negedge clk) begin
      if (rst_n) begin
         if (first_cas_cyc < 0 && !mem_cas_n) first_cas_cyc = cyc;
         if (first_cas_cyc < 0 && !mem_ras_n) early_req = 1'b1;
         if (init_cyc < 0 && init_done) init_cyc = cyc;
         if (!init_done && (ref_req || ref_urgent)) early_req = 1'b1;
         if (first_req_cyc < 0 && ref_req) first_req_cyc = cyc;
         if (!mem_we_n || !mem_oe_n) check(1'b0, "R5 we_n/oe_n", {mem_we_n, mem_oe_n}, 3);
         if (prev_cas && !mem_cas_n) span_pulses = 0;
         if (prev_ras && !mem_ras_n) begin
            span_pulses++;
            ras_falls++;
            // R4
            check(!mem_cas_n && !prev_cas && mem_we_n, "R4 cbr order", {prev_cas, mem_cas_n}, 0);
         end
         if (!prev_cas && mem_cas_n) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected span", span_pulses, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               // R9 / R10 pulses per span
               check(span_pulses == e, "R9 R10 span pulses", span_pulses, e);
            end
         end
         prev_ras = mem_ras_n;
         prev_cas = mem_cas_n;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      int t0;
      int snap;
      repeat (3) @(negedge clk);
      // R1
      check(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
            {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 15);
      check(!init_done && !ref_req && !ref_urgent && !strobe_own, "R1 status in reset",
            {init_done, ref_req, ref_urgent, strobe_own}, 0);
      expect_span(INIT);
      ref_grant = 1'b1;
      rst_n = 1'b1;
      while (init_cyc < 0) @(negedge clk);
      t0 = init_cyc;
      // R2
      check(first_cas_cyc == PAUSE, "R2 pause length", first_cas_cyc, PAUSE);
      // R3
      check(t0 == PAUSE + LEAD + INIT*(ACT+PRE), "R3 init_done time", t0, PAUSE + LEAD + INIT*(ACT+PRE));
      check(!early_req, "R3 no request or strobe before time", early_req, 0);
      check(ras_falls == INIT, "R3 init pulses", ras_falls, INIT);
      expect_span(1);
      expect_span(1);
      wait_until(t0 + 2*INTV + 50);
      // R6
      check(first_req_cyc == t0 + INTV, "R6 first request", first_req_cyc, t0 + INTV);
      check(ras_falls == INIT + 2, "R6 one refresh per interval", ras_falls, INIT + 2);
      ref_grant = 1'b0;
      snap = ras_falls;
      wait_until(t0 + 9*INTV + 5);
      // R8
      check(!ref_urgent && ref_req, "R8 seven owed not urgent", ref_urgent, 0);
      wait_until(t0 + 10*INTV + 5);
      check(ref_urgent && ref_req, "R8 urgent at full backlog", ref_urgent, 1);
      wait_until(t0 + 12*INTV);
      // R7
      check(ras_falls == snap && !strobe_own, "R7 idle without grant", ras_falls, snap);
      expect_span(MAXP);
      ref_grant = 1'b1;
      @(negedge clk);
      check(strobe_own && !mem_cas_n, "R7 takes strobes after grant", strobe_own, 1);
      wait_until(t0 + 12*INTV + 70);
      ref_grant = 1'b0;
      check(!ref_req && !ref_urgent && exp_q.size() == 0, "R8 saturated drain", exp_q.size(), 0);
      wait_until(t0 + 19*INTV + 5);
      check(!ref_urgent, "R8 not urgent at seven", ref_urgent, 0);
      wait_until(t0 + 20*INTV + 5);
      check(ref_urgent, "R8 urgent at eight", ref_urgent, 1);
      expect_span(MAXP + 1);
      wait_until(t0 + 20*INTV + 79);
      ref_grant = 1'b1;
      wait_until(t0 + 21*INTV + 60);
      ref_grant = 1'b0;
      // R10
      check(!ref_req && exp_q.size() == 0, "R10 tick and completion together", exp_q.size(), 0);
      wait_until(t0 + 22*INTV + 5);
      check(ref_req && !strobe_own && mem_ras_n && mem_cas_n, "R7 request held without grant",
            {ref_req, strobe_own}, 2);
      check(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);
      finish_run();
   end
endmodule